// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins a 16-bit A bus to a 16-bit B bus through a tri-state transceiver. The transceiver is split into two 8-bit halves. Each half has its own active-low output enable, direction input, pair of capture clocks and pair of source selects. The halves can be run on their own or together as a single 16-bit path.

Each half holds two edge-triggered registers. One samples the A side and feeds the B side. The other samples the B side and feeds the A side. When a half drives a bus, it places on that bus either the live value of the opposite bus or the contents of that direction's register. When the output enable is deasserted, the half drives neither bus, but both registers still capture on their clock edges. The registers have no reset, so their contents are undefined until the first capture edge.

The bus ports are logical tri-state inout nets. Drive strength, power sequencing and analog effects are not modelled.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: Half 0 owns bits 7:0 and half 1 owns bits 15:8 of both buses. The controls of one half have no effect on the bits of the other half.
- R2: A rising edge on `clkAtoB[h]` loads the A-bus bits of half h into that half's A-to-B register.
- R3: A rising edge on `clkBtoA[h]` loads the B-bus bits of half h into that half's B-to-A register.
- R4: With `oeN[h]`=0 and `dirAtoB[h]`=1, half h drives its B bits and leaves its A bits undriven.
- R5: With `oeN[h]`=0 and `dirAtoB[h]`=0, half h drives its A bits and leaves its B bits undriven.
- R6: The select of the active direction chooses the driven value. A select of 0 passes the live opposite bus, and a select of 1 passes that direction's register (`selAtoB` for driving B, `selBtoA` for driving A).
- R7: With `oeN[h]`=1, half h drives neither its A bits nor its B bits.
- R8: Both registers of a half capture normally while that half is isolated.
- R9: While a half drives one bus, either or both registers still capture on their edges. A register that samples the driven bus stores the value the half is driving.
- R10: A half never drives its A bits and its B bits at the same time.
- R11: When the stored and live values are equal, changing the active select leaves the driven value unchanged. The output mux has no hazard between its two sources.
- R12: The select of the inactive direction has no effect on the driven bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| portA | inout | 16 | A bus, tri-state |
| portB | inout | 16 | B bus, tri-state |
| oeN | input | 2 | Active-low output enable, one bit per half |
| dirAtoB | input | 2 | 1: drive B from the A side, 0: drive A from the B side |
| clkAtoB | input | 2 | Rising-edge capture of A bits into the A-to-B register |
| clkBtoA | input | 2 | Rising-edge capture of B bits into the B-to-A register |
| selAtoB | input | 2 | Source for B: 1 = stored, 0 = live A |
| selBtoA | input | 2 | Source for A: 1 = stored, 0 = live B |

## Verification
Every bus value is combinational in the controls, the opposite bus and the registers, so a result is due in the same bench cycle as its stimulus. A register update becomes visible on the driven bus as soon as the capture edge has passed. The driver applies controls, bus values and any capture pulse in the first few nanoseconds after a rising edge of the bench clock, then queues the expected bus values. The monitor compares them at the following falling edge, after every capture edge in that cycle. An undriven port is checked by having the bench drive a pattern and then its complement onto it and reading back exactly what it drove.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes from the control decode to one half's datapath
  typedef struct packed {
    logic driveA;       // half places data on its A bits
    logic driveB;       // half places data on its B bits
    logic useStoredAb;  // B side takes the A-to-B register
    logic useStoredBa;  // A side takes the B-to-A register
  } xcvrStb_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic     outEnN,
  input  logic     dirAtoB,
  input  logic     selStoredAb,
  input  logic     selStoredBa,
  output xcvrStb_t stb
);

  // Only one of the two drive strobes can be true, whatever the inputs
  always_comb begin
    stb.driveA      = ~outEnN & ~dirAtoB;
    stb.driveB      = ~outEnN &  dirAtoB;
    stb.useStoredAb = selStoredAb;
    stb.useStoredBa = selStoredBa;
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clkAb,
  input  logic         clkBa,
  input  xcvrStb_t     stb,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] toA,
  output logic [W-1:0] toB
);

  logic [W-1:0] storedAb;
  logic [W-1:0] storedBa;

  // Capture registers, no reset
  always_ff @(posedge clkAb) storedAb <= aIn;
  always_ff @(posedge clkBa) storedBa <= bIn;

  // Two-input mux with the consensus term added: when both sources agree,
  // the output is held by stored&live while the select changes.
  function automatic logic [W-1:0] safeMux(input logic s,
                                           input logic [W-1:0] stored,
                                           input logic [W-1:0] live);
    return ({W{s}} & stored) | ({W{~s}} & live) | (stored & live);
  endfunction

  assign toB = safeMux(stb.useStoredAb, storedAb, aIn);
  assign toA = safeMux(stb.useStoredBa, storedBa, bIn);

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2
) (
  inout  wire  [HALF_W*NUM_HALVES-1:0] portA,
  inout  wire  [HALF_W*NUM_HALVES-1:0] portB,
  input  logic [NUM_HALVES-1:0]        oeN,
  input  logic [NUM_HALVES-1:0]        dirAtoB,
  input  logic [NUM_HALVES-1:0]        clkAtoB,
  input  logic [NUM_HALVES-1:0]        clkBtoA,
  input  logic [NUM_HALVES-1:0]        selAtoB,
  input  logic [NUM_HALVES-1:0]        selBtoA
);

  localparam int BUS_W = HALF_W * NUM_HALVES;

  logic [NUM_HALVES-1:0] driveAVec;
  logic [NUM_HALVES-1:0] driveBVec;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam int LO = h * HALF_W;

    xcvrStb_t          stb;
    logic [HALF_W-1:0] toA;
    logic [HALF_W-1:0] toB;

    xcvr_ctrl u_ctrl (
      .outEnN      (oeN[h]),
      .dirAtoB     (dirAtoB[h]),
      .selStoredAb (selAtoB[h]),
      .selStoredBa (selBtoA[h]),
      .stb         (stb)
    );

    xcvr_path #(.W(HALF_W)) u_path (
      .clkAb (clkAtoB[h]),
      .clkBa (clkBtoA[h]),
      .stb   (stb),
      .aIn   (portA[LO +: HALF_W]),
      .bIn   (portB[LO +: HALF_W]),
      .toA   (toA),
      .toB   (toB)
    );

    assign portA[LO +: HALF_W] = stb.driveA ? toA : {HALF_W{1'bz}};
    assign portB[LO +: HALF_W] = stb.driveB ? toB : {HALF_W{1'bz}};

    assign driveAVec[h] = stb.driveA;
    assign driveBVec[h] = stb.driveB;
  end

  // BUS_W kept for readers of the port widths
  if (BUS_W != HALF_W * NUM_HALVES) begin : g_bad_width
    $error("bus width mismatch");
  end

endmodule

// File: rtl/bidir_reg_xcvr_chk.sv
module bidir_reg_xcvr_chk #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2
) (
  input logic [HALF_W*NUM_HALVES-1:0] portA,
  input logic [HALF_W*NUM_HALVES-1:0] portB,
  input logic [NUM_HALVES-1:0]        oeN,
  input logic [NUM_HALVES-1:0]        dirAtoB,
  input logic [NUM_HALVES-1:0]        clkAtoB,
  input logic [NUM_HALVES-1:0]        clkBtoA,
  input logic [NUM_HALVES-1:0]        selAtoB,
  input logic [NUM_HALVES-1:0]        selBtoA,
  input logic [NUM_HALVES-1:0]        driveAVec,
  input logic [NUM_HALVES-1:0]        driveBVec
);

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    localparam int LO = h * HALF_W;

    logic [HALF_W-1:0] seenA;
    logic [HALF_W-1:0] seenB;

    // Drive decode seen from the ports
    always_comb begin
      if (!$isunknown({oeN[h], dirAtoB[h]})) begin
        p_one_side_r10: assert (!(driveAVec[h] && driveBVec[h]))
          else $error("half %0d drives both buses", h);
        if (oeN[h]) begin
          p_isolate_r7: assert (!driveAVec[h] && !driveBVec[h])
            else $error("half %0d drives while isolated", h);
        end else begin
          p_dir_b_r4: assert (driveBVec[h] == dirAtoB[h])
            else $error("half %0d B drive disagrees with direction", h);
          p_dir_a_r5: assert (driveAVec[h] == !dirAtoB[h])
            else $error("half %0d A drive disagrees with direction", h);
        end
      end
    end

    // Sample each bus at its capture edge
    always_ff @(posedge clkAtoB[h]) seenA <= portA[LO +: HALF_W];
    always_ff @(posedge clkBtoA[h]) seenB <= portB[LO +: HALF_W];

    // Stored-mode output must show the value sampled at the last edge
    always @(negedge clkAtoB[h]) begin
      if (oeN[h] === 1'b0 && dirAtoB[h] === 1'b1 && selAtoB[h] === 1'b1) begin
        p_cap_ab_r2: assert (portB[LO +: HALF_W] === seenA)
          else $error("half %0d A-to-B capture mismatch", h);
      end
    end

    always @(negedge clkBtoA[h]) begin
      if (oeN[h] === 1'b0 && dirAtoB[h] === 1'b0 && selBtoA[h] === 1'b1) begin
        p_cap_ba_r3: assert (portA[LO +: HALF_W] === seenB)
          else $error("half %0d B-to-A capture mismatch", h);
      end
    end
  end

endmodule

bind bidir_reg_xcvr bidir_reg_xcvr_chk #(
  .HALF_W     (HALF_W),
  .NUM_HALVES (NUM_HALVES)
) u_chk (
  .portA     (portA),
  .portB     (portB),
  .oeN       (oeN),
  .dirAtoB   (dirAtoB),
  .clkAtoB   (clkAtoB),
  .clkBtoA   (clkBtoA),
  .selAtoB   (selAtoB),
  .selBtoA   (selBtoA),
  .driveAVec (driveAVec),
  .driveBVec (driveBVec)
);

// File: tb/tb_bidir_reg_xcvr.sv
module tb_bidir_reg_xcvr;

  localparam int HW = 8;
  localparam int NH = 2;
  localparam int BW = HW * NH;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NH-1:0] oeN     = '1;
  logic [NH-1:0] dirAtoB = '0;
  logic [NH-1:0] clkAtoB = '0;
  logic [NH-1:0] clkBtoA = '0;
  logic [NH-1:0] selAtoB = '0;
  logic [NH-1:0] selBtoA = '0;

  logic [BW-1:0] tbA   = '0;
  logic [BW-1:0] tbB   = '0;
  logic [NH-1:0] tbEnA = '0;
  logic [NH-1:0] tbEnB = '0;

  wire [BW-1:0] portA;
  wire [BW-1:0] portB;

  for (genvar h = 0; h < NH; h++) begin : g_tbdrv
    assign portA[h*HW +: HW] = tbEnA[h] ? tbA[h*HW +: HW] : {HW{1'bz}};
    assign portB[h*HW +: HW] = tbEnB[h] ? tbB[h*HW +: HW] : {HW{1'bz}};
  end

  bidir_reg_xcvr #(.HALF_W(HW), .NUM_HALVES(NH)) dut (
    .portA   (portA),
    .portB   (portB),
    .oeN     (oeN),
    .dirAtoB (dirAtoB),
    .clkAtoB (clkAtoB),
    .clkBtoA (clkBtoA),
    .selAtoB (selAtoB),
    .selBtoA (selBtoA)
  );

  typedef struct {
    int          half;
    bit          onB;
    logic [HW-1:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // ---------------- driver side ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expectBus(int h, bit onB, logic [HW-1:0] v, string tag);
    expItem_t it;
    it.half = h; it.onB = onB; it.val = v; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic drvBus(int h, bit onB, logic [HW-1:0] v);
    if (onB) begin tbB[h*HW +: HW] = v; tbEnB[h] = 1'b1; end
    else     begin tbA[h*HW +: HW] = v; tbEnA[h] = 1'b1; end
  endtask

  task automatic relBus(int h, bit onB);
    if (onB) tbEnB[h] = 1'b0;
    else     tbEnA[h] = 1'b0;
  endtask

  task automatic pulseCap(int h, bit doAb, bit doBa);
    if (doAb) clkAtoB[h] = 1'b1;
    if (doBa) clkBtoA[h] = 1'b1;
    #1;
    clkAtoB[h] = 1'b0;
    clkBtoA[h] = 1'b0;
    #1;
  endtask

  // ---------------- monitor side ----------------
  always @(negedge clk) begin
    cycles++;
    for (int h = 0; h < NH; h++) begin
      // R10 contention flag: bench and block on the same bus
      if (!oeN[h] && !dirAtoB[h] && tbEnA[h]) begin
        errors++;
        $display("FAIL R10 half %0d A contention: got both drivers expected one", h);
      end
      if (!oeN[h] && dirAtoB[h] && tbEnB[h]) begin
        errors++;
        $display("FAIL R10 half %0d B contention: got both drivers expected one", h);
      end
    end
    while (expQ.size() > 0) begin
      expItem_t it;
      logic [HW-1:0] act;
      it  = expQ.pop_front();
      act = it.onB ? portB[it.half*HW +: HW] : portA[it.half*HW +: HW];
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s half %0d bus %s: got %h expected %h",
                 it.tag, it.half, it.onB ? "B" : "A", act, it.val);
      end
    end
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    tick();
    // Idle: all isolated, bench values read back, then complement (R7)
    drvBus(0, 0, 8'hA5); drvBus(0, 1, 8'h3C);
    drvBus(1, 0, 8'h5A); drvBus(1, 1, 8'hC3);
    expectBus(0, 0, 8'hA5, "R7"); expectBus(0, 1, 8'h3C, "R7");
    expectBus(1, 0, 8'h5A, "R7"); expectBus(1, 1, 8'hC3, "R7");
    tick();
    drvBus(0, 0, 8'h5A); drvBus(0, 1, 8'hC3);
    drvBus(1, 0, 8'hA5); drvBus(1, 1, 8'h3C);
    expectBus(0, 0, 8'h5A, "R7"); expectBus(0, 1, 8'hC3, "R7");
    expectBus(1, 0, 8'hA5, "R7"); expectBus(1, 1, 8'h3C, "R7");

    // Capture while isolated (R8): half0 12/34, half1 56/78
    tick();
    drvBus(0, 0, 8'h12); drvBus(0, 1, 8'h34);
    drvBus(1, 0, 8'h56); drvBus(1, 1, 8'h78);
    pulseCap(0, 1, 1);
    pulseCap(1, 1, 1);

    // Half0 drives B from stored A-to-B register (R2 R4 R6 R8)
    tick();
    relBus(0, 1);
    dirAtoB[0] = 1'b1; selAtoB[0] = 1'b1; oeN[0] = 1'b0;
    drvBus(0, 0, 8'h9A);
    expectBus(0, 1, 8'h12, "R2_R8_stored");
    expectBus(0, 0, 8'h9A, "R4_A_undriven");
    expectBus(1, 1, 8'h78, "R1_other_half");
    expectBus(1, 0, 8'h56, "R1_other_half");

    // Live A onto B (R6), complement on A still reads back (R4)
    tick();
    selAtoB[0] = 1'b0;
    drvBus(0, 0, 8'h65);
    expectBus(0, 1, 8'h65, "R6_live_ab");
    expectBus(0, 0, 8'h65, "R4_A_undriven");

    // Inactive select has no effect on B (R12)
    tick();
    selBtoA[0] = 1'b1;
    expectBus(0, 1, 8'h65, "R12_inactive_sel");
    tick();
    selBtoA[0] = 1'b0;
    expectBus(0, 1, 8'h65, "R12_inactive_sel");

    // Turn half0 around: drive A from stored B-to-A register (R3 R5 R6)
    tick();
    oeN[0] = 1'b1;
    relBus(0, 0);
    dirAtoB[0] = 1'b0; selBtoA[0] = 1'b1; oeN[0] = 1'b0;
    drvBus(0, 1, 8'hE7);
    expectBus(0, 0, 8'h34, "R3_stored_ba");
    expectBus(0, 1, 8'hE7, "R5_B_undriven");
    tick();
    drvBus(0, 1, 8'h18);
    expectBus(0, 1, 8'h18, "R5_B_undriven");
    expectBus(0, 0, 8'h34, "R3_stored_ba");

    // Live B onto A (R6)
    tick();
    selBtoA[0] = 1'b0;
    drvBus(0, 1, 8'hC7);
    expectBus(0, 0, 8'hC7, "R6_live_ba");

    // Capture both registers while driving A (R9): both sample C7
    tick();
    pulseCap(0, 1, 1);
    selBtoA[0] = 1'b1;
    expectBus(0, 0, 8'hC7, "R9_ba_capture");

    // Reverse and show the A-to-B register holds the driven value (R9)
    tick();
    oeN[0] = 1'b1;
    relBus(0, 1);
    dirAtoB[0] = 1'b1; selAtoB[0] = 1'b1; oeN[0] = 1'b0;
    drvBus(0, 0, 8'h00);
    expectBus(0, 1, 8'hC7, "R9_ab_capture");

    // Stored equals live: select changes leave B at C7 (R11)
    tick();
    drvBus(0, 0, 8'hC7);
    selAtoB[0] = 1'b0; #1; selAtoB[0] = 1'b1; #1; selAtoB[0] = 1'b0;
    expectBus(0, 1, 8'hC7, "R11_no_glitch");
    tick();
    selAtoB[0] = 1'b1;
    expectBus(0, 1, 8'hC7, "R11_no_glitch");

    // New capture in stored mode updates B at once (R2)
    tick();
    drvBus(0, 0, 8'h4B);
    pulseCap(0, 1, 0);
    expectBus(0, 1, 8'h4B, "R2_recapture");

    // Half1 drives A from stored 78 while half0 keeps driving B (R1 R3)
    tick();
    relBus(1, 0);
    dirAtoB[1] = 1'b0; selBtoA[1] = 1'b1; oeN[1] = 1'b0;
    drvBus(1, 1, 8'h11);
    expectBus(1, 0, 8'h78, "R1_R3_half1");
    expectBus(0, 1, 8'h4B, "R1_half0_kept");

    // Isolate half0 again; half1 unaffected (R7 R1)
    tick();
    oeN[0] = 1'b1;
    drvBus(0, 1, 8'h2D);
    expectBus(0, 1, 8'h2D, "R7_reisolate");
    expectBus(0, 0, 8'h4B, "R7_reisolate");
    expectBus(1, 0, 8'h78, "R1_half1_kept");

    tick();
    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule